// File: doc/BRIEF.md
# Split-Transaction Timeout Timer

This block holds the two control registers that set how long a requester waits for the response half of a split transaction. It also runs the countdown that flags the wait as over. The interval has two parts: a whole-seconds field in one register, and a fraction of a second counted in 125 µs steps in the top 13 bits of a second register. Both are reached through a small quadlet register port. Writes keep only the meaningful bits, and every request is answered one cycle later with a response code and read data.

The time base is a one-cycle tick input that pulses every 125 µs. A start pulse loads a down-counter with the programmed interval, expressed in ticks and never shorter than 100 ms (800 ticks). Each tick decrements the counter. When the last tick of the interval arrives, `expired` pulses for one cycle, unless a completion pulse has cancelled the wait first. Only one outstanding transaction is tracked at a time.

Top module: `split_timeout_timer`

## Requirements
- R1: After reset, the seconds register reads 0 and the fraction register reads 0x19000000 (800 in bits [31:19], a 100 ms interval), and `expired` is low.
- R2: A write to the seconds register (byte offset 0x0) stores only wdata[2:0]; a later read returns that value with bits [31:3] zero.
- R3: A write to the fraction register (byte offset 0x4) stores only wdata[31:19]; a later read returns that field in bits [31:19] with bits [18:0] zero.
- R4: Every request receives `rsp_valid` high in the following cycle. A successful access has `rsp_code` 0, reads carry the register value in `rsp_rdata`, and writes return 0.
- R5: A request with a byte address whose bits [1:0] are not 00 returns `rsp_code` 1 (type error) and data 0, and changes no register.
- R6: An aligned request to any offset other than 0x0 and 0x4 returns `rsp_code` 2 (address error) and data 0, and changes no register.
- R7: After a start pulse, `expired` rises after the N-th tick, where N = seconds×8000 + fraction.
- R8: When seconds×8000 + fraction is below 800, N is 800.
- R9: `expired` is high for exactly one cycle, in the cycle after the clock edge that samples the final tick, and it does not repeat until the next start.
- R10: A completion pulse ends the wait with no expiry, even when it coincides with the final tick.
- R11: A start pulse during a wait reloads the full interval and counts from that pulse.
- R12: A register write during a wait does not alter the running count; the new value applies from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 4 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| rsp_rdata | output | 32 | Read data, 0 for writes and errors |
| tick | input | 1 | 125 µs time-base pulse |
| xact_start | input | 1 | Start waiting for a response |
| xact_done | input | 1 | Response arrived; cancel the wait |
| expired | output | 1 | One-cycle timeout indication |

## Verification
The register port is tested with all-ones and sparse write patterns. These show whether masking keeps exactly the writable field of each register. Misaligned and unmapped offsets are also tested, to check that the two error codes differ and that a rejected write leaves the stored value unchanged. The countdown is run with a settings below the floor (zero, and one tick under it), one tick above the floor, and a setting with a nonzero seconds field. These separate the clamp from the plain sum and confirm the seconds weighting of 8000. Cancellation on the final tick, a restart part-way through a wait, and a rewrite part-way through a wait show which of two simultaneous events takes precedence and when new settings are sampled.

// File: rtl/sto_pkg.sv
package sto_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    RSP_OK       = 2'd0,
    RSP_TYPE_ERR = 2'd1,
    RSP_ADDR_ERR = 2'd2
  } rsp_code_e;

endpackage

// File: rtl/sto_rst_sync.sv
module sto_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/sto_regs.sv
module sto_regs
  import sto_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int SEC_W      = 3,
  parameter int FRAC_W     = 13,
  parameter int RESET_FRAC = 800,
  parameter int OFS_SEC    = 0,
  parameter int OFS_FRAC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rsp_valid,
  output rsp_code_e         rsp_code,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [SEC_W-1:0]  sec_q,
  output logic [FRAC_W-1:0] frac_q
);

  localparam int FRAC_LSB = DATA_W - FRAC_W;

  logic              aligned;
  logic              hit_sec;
  logic              hit_frac;
  logic              wr_en;
  logic              rsp_en;
  logic [SEC_W-1:0]  sec_d;
  logic [FRAC_W-1:0] frac_d;
  logic              rsp_valid_d;
  rsp_code_e         rsp_code_d;
  logic [DATA_W-1:0] rsp_rdata_d;
  logic              unused_wbits;

  assign aligned  = (addr[1:0] == 2'b00);
  assign hit_sec  = (addr == ADDR_W'(OFS_SEC));
  assign hit_frac = (addr == ADDR_W'(OFS_FRAC));
  assign wr_en    = req && we && aligned && (hit_sec || hit_frac);
  assign rsp_en   = req || rsp_valid;

  // Bits between the two fields are never stored.
  assign unused_wbits = ^wdata[FRAC_LSB-1:SEC_W];

  always_comb begin
    sec_d       = sec_q;
    frac_d      = frac_q;
    rsp_valid_d = req;
    rsp_code_d  = RSP_OK;
    rsp_rdata_d = '0;
    if (req) begin
      if (!aligned) begin
        rsp_code_d = RSP_TYPE_ERR;
      end else if (hit_sec) begin
        if (we) sec_d = wdata[SEC_W-1:0];
        else    rsp_rdata_d = DATA_W'(sec_q);
      end else if (hit_frac) begin
        if (we) frac_d = wdata[DATA_W-1:FRAC_LSB];
        else    rsp_rdata_d = {frac_q, {FRAC_LSB{1'b0}}};
      end else begin
        rsp_code_d = RSP_ADDR_ERR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      frac_q <= FRAC_W'(RESET_FRAC);
    end else if (wr_en) begin
      sec_q  <= sec_d;
      frac_q <= frac_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_OK;
      rsp_rdata <= '0;
    end else if (rsp_en) begin
      rsp_valid <= rsp_valid_d;
      rsp_code  <= rsp_code_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

endmodule

// File: rtl/sto_interval.sv
module sto_interval #(
  parameter int SEC_W         = 3,
  parameter int FRAC_W        = 13,
  parameter int TICKS_PER_SEC = 8000,
  parameter int MIN_TICKS     = 800,
  parameter int CNT_W         = 16
) (
  input  logic [SEC_W-1:0]  sec,
  input  logic [FRAC_W-1:0] frac,
  output logic [CNT_W-1:0]  ticks
);

  logic [CNT_W-1:0] raw;

  always_comb begin
    raw   = CNT_W'(sec) * CNT_W'(TICKS_PER_SEC) + CNT_W'(frac);
    ticks = (raw < CNT_W'(MIN_TICKS)) ? CNT_W'(MIN_TICKS) : raw;
  end

endmodule

// File: rtl/sto_countdown.sv
module sto_countdown #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             done,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_d;
  logic             cnt_en;

  // start beats done, done beats the final tick
  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    exp_d    = 1'b0;
    if (start) begin
      active_d = 1'b1;
      cnt_d    = load_val;
    end else if (done) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (active_q && tick) begin
      if (cnt_q == CNT_W'(1)) begin
        active_d = 1'b0;
        cnt_d    = '0;
        exp_d    = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_en = start || done || (active_q && tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cnt_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expired <= 1'b0;
    end else begin
      expired <= exp_d;
    end
  end

endmodule

// File: rtl/split_timeout_timer.sv
module split_timeout_timer
  import sto_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int SEC_W         = 3,
  parameter int FRAC_W        = 13,
  parameter int TICKS_PER_SEC = 8000,
  parameter int MIN_TICKS     = 800,
  parameter int RESET_FRAC    = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [31:0]       rsp_rdata,
  input  logic              tick,
  input  logic              xact_start,
  input  logic              xact_done,
  output logic              expired
);

  localparam int MAX_TICKS = ((2 ** SEC_W) - 1) * TICKS_PER_SEC + (2 ** FRAC_W) - 1;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic              rst_int_n;
  logic [SEC_W-1:0]  sec_q;
  logic [FRAC_W-1:0] frac_q;
  logic [CNT_W-1:0]  interval_ticks;
  rsp_code_e         code_e;

  sto_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sto_regs #(
    .ADDR_W     (ADDR_W),
    .SEC_W      (SEC_W),
    .FRAC_W     (FRAC_W),
    .RESET_FRAC (RESET_FRAC)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req       (reg_req),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rsp_valid (rsp_valid),
    .rsp_code  (code_e),
    .rsp_rdata (rsp_rdata),
    .sec_q     (sec_q),
    .frac_q    (frac_q)
  );

  assign rsp_code = code_e;

  sto_interval #(
    .SEC_W         (SEC_W),
    .FRAC_W        (FRAC_W),
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .MIN_TICKS     (MIN_TICKS),
    .CNT_W         (CNT_W)
  ) u_interval (
    .sec   (sec_q),
    .frac  (frac_q),
    .ticks (interval_ticks)
  );

  sto_countdown #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (xact_start),
    .done     (xact_done),
    .tick     (tick),
    .load_val (interval_ticks),
    .expired  (expired)
  );

endmodule

// File: rtl/sto_checker.sv
module sto_checker #(
  parameter int ADDR_W = 4,
  parameter int SEC_W  = 3,
  parameter int FRAC_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_req,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic [31:0]       rsp_rdata,
  input logic              tick,
  input logic              xact_start,
  input logic              xact_done,
  input logic              expired
);

  localparam int FRAC_LSB = 32 - FRAC_W;

  logic unused_chk;
  assign unused_chk = ^{reg_wdata, rsp_code};

  assert_rsp_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> rsp_valid);

  assert_no_spurious_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_req |=> !rsp_valid);

  assert_misaligned_type_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_addr[1:0] != 2'b00) |=> (rsp_code == 2'd1 && rsp_rdata == 32'd0));

  assert_sec_read_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we && reg_addr == ADDR_W'(0)) |=> (rsp_rdata[31:SEC_W] == '0));

  assert_frac_read_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we && reg_addr == ADDR_W'(4)) |=> (rsp_rdata[FRAC_LSB-1:0] == '0));

  assert_expire_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired);

  assert_expire_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(tick));

  assert_done_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_done && !xact_start) |=> !expired);

  assert_start_no_expire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xact_start |=> !expired);

endmodule

bind split_timeout_timer sto_checker #(
  .ADDR_W (ADDR_W),
  .SEC_W  (SEC_W),
  .FRAC_W (FRAC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_req    (reg_req),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_code   (rsp_code),
  .rsp_rdata  (rsp_rdata),
  .tick       (tick),
  .xact_start (xact_start),
  .xact_done  (xact_done),
  .expired    (expired)
);

// File: tb/split_timeout_timer_test.sv
`timescale 1ns/1ps
module split_timeout_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_rdata;
  logic        tick = 1'b0;
  logic        xact_start = 1'b0;
  logic        xact_done = 1'b0;
  logic        expired;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  split_timeout_timer uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .rsp_rdata  (rsp_rdata),
    .tick       (tick),
    .xact_start (xact_start),
    .xact_done  (xact_done),
    .expired    (expired)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [1:0]  code;
    logic [31:0] rdata;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'h0, 32'h0,        2'd0, 32'h0,        4'd1},  // R1
    '{1'b0, 4'h4, 32'h0,        2'd0, 32'h19000000, 4'd1},  // R1
    '{1'b1, 4'h0, 32'hFFFFFFFD, 2'd0, 32'h0,        4'd4},  // R4
    '{1'b0, 4'h0, 32'h0,        2'd0, 32'h5,        4'd2},  // R2
    '{1'b1, 4'h4, 32'hFFFFFFFF, 2'd0, 32'h0,        4'd4},  // R4
    '{1'b0, 4'h4, 32'h0,        2'd0, 32'hFFF80000, 4'd3},  // R3
    '{1'b1, 4'h4, 32'h0007FFFF, 2'd0, 32'h0,        4'd3},  // R3
    '{1'b0, 4'h4, 32'h0,        2'd0, 32'h0,        4'd3},  // R3
    '{1'b1, 4'h2, 32'h7,        2'd1, 32'h0,        4'd5},  // R5
    '{1'b0, 4'h0, 32'h0,        2'd0, 32'h5,        4'd5},  // R5
    '{1'b0, 4'h1, 32'h0,        2'd1, 32'h0,        4'd5},  // R5
    '{1'b1, 4'h8, 32'h2,        2'd2, 32'h0,        4'd6},  // R6
    '{1'b0, 4'hC, 32'h0,        2'd2, 32'h0,        4'd6},  // R6
    '{1'b0, 4'h0, 32'h0,        2'd0, 32'h5,        4'd6},  // R6
    '{1'b1, 4'h0, 32'h0,        2'd0, 32'h0,        4'd2},  // R2
    '{1'b1, 4'h4, 32'h19000000, 2'd0, 32'h0,        4'd3},  // R3
    '{1'b0, 4'h4, 32'h0,        2'd0, 32'h19000000, 4'd3}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [3:0] addr, input logic [31:0] wdata,
                        output logic [1:0] code, output logic [31:0] rdata, output logic vld);
    @(negedge clk);
    reg_req = 1'b1; reg_we = we; reg_addr = addr; reg_wdata = wdata;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
    vld = rsp_valid; code = rsp_code; rdata = rsp_rdata;
  endtask

  task automatic wr(input logic [3:0] addr, input logic [31:0] wdata);
    logic [1:0] c; logic [31:0] d; logic v;
    access(1'b1, addr, wdata, c, d, v);
  endtask

  task automatic pulse_start();
    @(negedge clk); xact_start = 1'b1;
    @(negedge clk); xact_start = 1'b0;
  endtask

  // Issue n ticks two cycles apart; record first expiry and count pulses.
  task automatic run_ticks(input int n, inout int first, inout int count, inout int longp);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (expired) begin
        count++;
        if (first == 0) first = i;
      end
    end
    @(negedge clk);
    if (expired) longp++;
  endtask

  task automatic timed(input string req, input int ticks_to_run, input int exp_first);
    int first = 0; int count = 0; int longp = 0;
    pulse_start();
    run_ticks(ticks_to_run, first, count, longp);
    check(req, first, exp_first);
    check(req, count, 1);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0]  c;
    logic [31:0] d;
    logic        v;
    int first, count, longp;

    repeat (3) @(negedge clk);
    check("R1 expired at reset", expired, 0);
    check("R1 rsp_valid at reset", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Register vector table
    for (int k = 0; k < NVEC; k++) begin
      access(VECS[k].we, VECS[k].addr, VECS[k].wdata, c, d, v);
      check($sformatf("R%0d vec %0d valid", VECS[k].req, k), v, 1);
      check($sformatf("R%0d vec %0d code", VECS[k].req, k), c, VECS[k].code);
      check($sformatf("R%0d vec %0d rdata", VECS[k].req, k), d, VECS[k].rdata);
    end

    // R7 default 800 ticks, R9 single pulse
    first = 0; count = 0; longp = 0;
    pulse_start();
    run_ticks(810, first, count, longp);
    check("R7 default expiry tick", first, 800);
    check("R9 one pulse", count, 1);
    check("R9 pulse width", longp, 0);

    // R8 clamp
    wr(4'h4, 32'h0);
    timed("R8 zero setting clamps", 805, 800);
    wr(4'h4, 32'd799 << 19);
    timed("R8 799 clamps", 805, 800);
    wr(4'h4, 32'd801 << 19);
    timed("R7 801 ticks", 805, 801);

    // R7 seconds weighting
    wr(4'h0, 32'h1);
    wr(4'h4, 32'd5 << 19);
    timed("R7 one second plus 5", 8010, 8005);
    wr(4'h0, 32'h0);

    // R10 completion cancels
    wr(4'h4, 32'd1000 << 19);
    first = 0; count = 0; longp = 0;
    pulse_start();
    run_ticks(500, first, count, longp);
    @(negedge clk); xact_done = 1'b1;
    @(negedge clk); xact_done = 1'b0;
    run_ticks(600, first, count, longp);
    check("R10 cancelled no expiry", count, 0);

    // R10 completion on the final tick
    first = 0; count = 0; longp = 0;
    pulse_start();
    run_ticks(999, first, count, longp);
    @(negedge clk); tick = 1'b1; xact_done = 1'b1;
    @(negedge clk); tick = 1'b0; xact_done = 1'b0;
    if (expired) count++;
    run_ticks(5, first, count, longp);
    check("R10 done with final tick", count, 0);

    // R11 restart reloads
    first = 0; count = 0; longp = 0;
    pulse_start();
    run_ticks(300, first, count, longp);
    timed("R11 restart counts anew", 1005, 1000);

    // R12 rewrite mid-wait keeps running count
    first = 0; count = 0; longp = 0;
    pulse_start();
    run_ticks(10, first, count, longp);
    wr(4'h4, 32'd2000 << 19);
    run_ticks(995, first, count, longp);
    check("R12 running count unchanged", first, 990);
    check("R12 single expiry", count, 1);
    timed("R12 new value on next start", 2005, 2000);

    // R1 reset mid-wait
    pulse_start();
    first = 0; count = 0; longp = 0;
    run_ticks(100, first, count, longp);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 expired during reset", expired, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    access(1'b0, 4'h4, 32'h0, c, d, v);
    check("R1 fraction after reset", d, 32'h19000000);
    first = 0; count = 0; longp = 0;
    run_ticks(900, first, count, longp);
    check("R1 no expiry after reset", count, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule